// File: doc/BRIEF.md
# Chainable Serial-to-Parallel Output Register

This block turns a serial bit stream into a parallel output word. Each enabled clock cycle moves one new bit into a shift register. A level-controlled load input copies that register into a holding register, and a mute input can force every parallel output to zero without disturbing any stored state. The last stage of the shift register is also brought out as a serial output, so several blocks can be chained into a longer word by feeding one block's serial output into the next block's serial input.

The block is fully synchronous to `clk`. An asynchronous active-low reset clears both registers. The internal reset is released only after a short synchroniser, so the block ignores its inputs for `SYNC_STAGES` clock edges after `rst_n` rises. The usual way to load a new word is to assert the mute input, shift in the word, pulse the load input, and then release the mute.

Top module: `spo_stage`

## Requirements
- R1: While reset is active, and for the first SYNC_STAGES (default 2) rising edges after `rst_n` is released, the shift register and the holding register are zero, so `pout` and `sdout` are 0 whatever the other inputs are.
- R2: On a rising edge with `shift_en` high, `sdin` enters bit 0 of the shift register and every other bit moves up one place (bit i goes to bit i+1). After W shifts, the first bit shifted in sits in bit W-1.
- R3: On a rising edge with `shift_en` low, the shift register keeps its value.
- R4: `sdout` always equals bit W-1 of the shift register, so a bit appears on `sdout` after W enabled shifts.
- R5: On a rising edge with `load` high, the holding register takes the shift register value present just before that edge. Holding `load` high for several cycles makes it follow the shift register one cycle behind.
- R6: On a rising edge with `load` low, the holding register keeps its value.
- R7: While `mute` is low, each `pout[i]` equals bit i of the holding register, combinationally.
- R8: While `mute` is high, every bit of `pout` is 0.
- R9: `mute` has no effect on either register. After `mute` is released, `pout` again shows the held word, and later loads and shifts proceed as if `mute` had never been asserted.

Parameter `W` (default 8) is the width of both registers. `SYNC_STAGES` (default 2) is the length of the reset synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| sdin | input | 1 | Serial bit taken into stage 0 |
| shift_en | input | 1 | Shifts the register on the next rising edge |
| load | input | 1 | Level-controlled copy of the shift register into the holding register |
| mute | input | 1 | Active-high; forces all parallel outputs to 0 |
| pout | output | W | Parallel outputs, gated by `mute` |
| sdout | output | 1 | Last shift stage, used for chaining |

## Verification
The checker assumes that every input is synchronous to `clk` and stable around its rising edge. It also assumes that its disable condition is the internally synchronised reset rather than the raw pin, because the block ignores its inputs while the synchroniser is still flushing. The bench changes every input only on the falling edge, and it starts stimulus during the synchroniser window on purpose, to show that those cycles have no effect. Random traffic mixes shift, load and mute in every combination, including load and shift in the same cycle. Directed sequences cover a full-width word, idle hold periods and mute toggles in the middle of a cycle.

// File: rtl/spo_pkg.sv
package spo_pkg;
  localparam int SPO_W_DEFAULT    = 8;
  localparam int SPO_SYNC_DEFAULT = 2;

  typedef struct packed {
    logic shift;
    logic load;
    logic mute;
  } spo_ctl_t;
endpackage

// File: rtl/spo_rst_sync.sv
module spo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/spo_shift.sv
module spo_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q_r;
    if (en) q_nx = {q_r[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/spo_hold.sv
module spo_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q_r;
    if (load) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/spo_gate.sv
module spo_gate #(
  parameter int W = 8
) (
  input  logic         mute,
  input  logic [W-1:0] d,
  output logic [W-1:0] y
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign y[i] = d[i] & ~mute;
    end
  endgenerate
endmodule

// File: rtl/spo_stage.sv
module spo_stage
  import spo_pkg::*;
#(
  parameter int W           = SPO_W_DEFAULT,
  parameter int SYNC_STAGES = SPO_SYNC_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdin,
  input  logic         shift_en,
  input  logic         load,
  input  logic         mute,
  output logic [W-1:0] pout,
  output logic         sdout
);
  localparam int TAIL = W - 1;

  spo_ctl_t     ctl;
  logic         rst_q;
  logic [W-1:0] sr_q;
  logic [W-1:0] lat_q;

  assign ctl = '{shift: shift_en, load: load, mute: mute};

  spo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  spo_shift #(.W(W)) u_shift (
    .clk   (clk),
    .rst_n (rst_q),
    .en    (ctl.shift),
    .din   (sdin),
    .q     (sr_q)
  );

  spo_hold #(.W(W)) u_hold (
    .clk   (clk),
    .rst_n (rst_q),
    .load  (ctl.load),
    .d     (sr_q),
    .q     (lat_q)
  );

  spo_gate #(.W(W)) u_gate (
    .mute (ctl.mute),
    .d    (lat_q),
    .y    (pout)
  );

  assign sdout = sr_q[TAIL];
endmodule

// File: rtl/spo_stage_chk.sv
module spo_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sdin,
  input logic         shift_en,
  input logic         load,
  input logic         mute,
  input logic [W-1:0] sr,
  input logic [W-1:0] lat,
  input logic [W-1:0] pout
);
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr == {$past(sr[W-2:0]), $past(sdin)});

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> lat == $past(sr));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lat));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |-> pout == lat);

  assert_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> $countones(pout) == 0);
endmodule

bind spo_stage spo_stage_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .sdin     (sdin),
  .shift_en (shift_en),
  .load     (load),
  .mute     (mute),
  .sr       (sr_q),
  .lat      (lat_q),
  .pout     (pout)
);

// File: tb/spo_stage_test.sv
`timescale 1ns/1ps
module spo_stage_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sdin, shift_en, load, mute;
  logic [W-1:0] pout;
  logic         sdout;

  logic [W-1:0] ref_sr, ref_lat;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #10 clk = ~clk;

  spo_stage #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sdin(sdin), .shift_en(shift_en),
    .load(load), .mute(mute), .pout(pout), .sdout(sdout)
  );

  function automatic logic [W-1:0] exp_pout();
    return mute ? '0 : ref_lat;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(req, 32'(pout), 32'(exp_pout()));
    check(req, 32'(sdout), 32'(ref_sr[W-1]));
  endtask

  task automatic tick();
    @(posedge clk);
    if (load)     ref_lat = ref_sr;
    if (shift_en) ref_sr  = {ref_sr[W-2:0], sdin};
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [W-1:0] pat;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sdin = 1'b1; shift_en = 1'b1; load = 1'b1; mute = 1'b0;
    ref_sr = '0; ref_lat = '0;
    repeat (3) @(negedge clk);
    check_outs("R1 reset held");

    // R1: inputs active during the synchroniser window must be ignored
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_outs("R1 sync window");

    // R2/R4/R8: shift a full word while muted
    pat = 8'b1011_0001;
    load = 1'b0; mute = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      sdin = pat[i];
      tick();
      check_outs("R2 R4 R8 shifting muted");
    end
    check("R2 first bit at top", 32'(sdout), 32'(pat[W-1]));

    // R5: load the word, still muted
    shift_en = 1'b0; load = 1'b1;
    tick();
    check("R8 muted after load", 32'(pout), 32'h0);
    load = 1'b0;
    mute = 1'b0; #1;
    check("R7 word shown", 32'(pout), 32'(pat));
    mute = 1'b1; #1;
    check("R8 mute mid cycle", 32'(pout), 32'h0);
    mute = 1'b0; #1;
    check("R9 word kept after mute", 32'(pout), 32'(pat));

    // R3: no shift while shift_en is low, whatever sdin does
    for (int i = 0; i < 5; i++) begin
      sdin = 1'($urandom);
      mute = 1'($urandom);
      tick();
      check_outs("R3 R9 idle");
    end
    mute = 1'b0; load = 1'b1;
    tick();
    check("R3 reload unchanged", 32'(pout), 32'(pat));

    // R6: shifting with load low leaves the held word alone
    load = 1'b0; shift_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sdin = ~sdin;
      tick();
      check("R6 held word", 32'(pout), 32'(pat));
    end

    // R5: load and shift together, holding register trails by one cycle
    load = 1'b1;
    for (int i = 0; i < W; i++) begin
      sdin = 1'($urandom);
      tick();
      check_outs("R5 transparent follow");
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      sdin     = 1'($urandom);
      shift_en = 1'($urandom);
      load     = ($urandom % 4) == 0;
      mute     = ($urandom % 3) == 0;
      tick();
      check_outs("R2 R3 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    summary();
  end
endmodule